// File: doc/BRIEF.md
# Privileged CSR Access Unit

This block holds the control and status registers of a small CPU core and carries out the three register-access operations the core issues from its execute stage:

- **Read** returns the register's contents.
- **Write** stores the source word and returns what the register held before.
- **Masked exchange** replaces only the bits selected by a mask word and returns the previous contents.

Each request is presented for one cycle with a 14-bit register number, a source word, a mask word, an operation code and the current privilege level. One cycle later the unit answers with a response strobe and read data. Alongside the data it raises either an exception request with a cause code, or a flush request. The flush request tells the pipeline that a mode-affecting register changed.

The register number is decoded into one of three classes:

- Writable registers: four mode registers, a bank of scratch save registers and a bank of address-window registers.
- Read-only registers: the core index, taken from an input port, and three configuration words fixed by parameters.
- Undefined numbers: everything else.

The response logic is a small state machine with three states:

- `ST_IDLE`: no response this cycle.
- `ST_DONE`: the operation completed.
- `ST_TRAP`: the operation raised an exception and changed nothing.

Every cycle the machine takes one of three transitions:

- "no request" goes to `ST_IDLE`.
- "privilege fault" or "read-only write" goes to `ST_TRAP`.
- "accepted" goes to `ST_DONE`.

Top module: `csr_access_unit`

## Requirements
- R1: A request at privilege level 3 (user) of any operation gives `exc_valid`=1 with `exc_cause`=0x0E, `rsp_data`=0 and `flush_req`=0, and changes no register.
- R2: A read of an undefined number returns 0 with no exception. The defined numbers are 0x000, 0x001, 0x005, 0x018, 0x020..0x023, 0x030..0x03F and 0x180..0x183.
- R3: A write or exchange to an undefined number is discarded, returns 0, and raises neither an exception nor a flush.
- R4: A write or exchange to a read-only number (0x020..0x023) gives `exc_valid`=1 with `exc_cause`=0x0D and `rsp_data`=0, and the register keeps its value.
- R5: A write (op code 1) stores the source word and returns the previous contents.
- R6: An exchange (op code 2) stores (src AND mask) OR (old AND NOT mask) and returns the previous contents.
- R7: `flush_req` is 1 exactly for an accepted write or exchange to 0x000, 0x001, 0x005 or 0x018. It is 0 for reads and for all other numbers.
- R8: The 16 scratch registers (0x030..0x03F) and 4 window registers (0x180..0x183) each hold their own value.
- R9: A read (op code 0, or the spare op code 3) of 0x020 returns `core_id` zero-extended. Reads of 0x021, 0x022 and 0x023 return the parameters CFG0, CFG1 and CFG2.
- R10: `rsp_valid` is 1 in exactly the cycle after each cycle with `req_valid`=1.
- R11: After reset every writable register reads 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 exchange, 3 read |
| req_addr | input | 14 | Register number |
| req_src | input | DW | Source data word |
| req_mask | input | DW | Exchange mask |
| req_plv | input | 2 | Privilege level, 3 is user |
| core_id | input | CORE_W | Core index returned by 0x020 |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | DW | Read or previous value |
| exc_valid | output | 1 | Exception request |
| exc_cause | output | 6 | Exception cause code |
| flush_req | output | 1 | Pipeline flush request |

## Verification
Register state appears at the ports only through the old value returned by a later write, exchange or read. A corrupted register or a misdirected write therefore shows on the very next access to the affected number, not when the damage happens. For that reason the bench reads back every scratch and window register after filling them with distinct values, and re-reads registers after trapped or discarded operations. A wrong outcome state shows on `exc_valid`, `exc_cause` and `flush_req` one cycle after the faulty request.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int AW = 14;
    localparam int CW = 6;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_XCHG  = 2'd2,
        OP_SPARE = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        CLS_UNDEF = 2'd0,
        CLS_RW    = 2'd1,
        CLS_RO    = 2'd2
    } csr_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_TRAP = 2'd2
    } rsp_state_e;

    localparam logic [1:0]    PLV_USER   = 2'd3;
    localparam logic [CW-1:0] CAUSE_PRIV = 6'h0E;
    localparam logic [CW-1:0] CAUSE_RO   = 6'h0D;

    localparam logic [AW-1:0] A_MODE  = 14'h000;
    localparam logic [AW-1:0] A_UNITS = 14'h001;
    localparam logic [AW-1:0] A_XSTAT = 14'h005;
    localparam logic [AW-1:0] A_SPACE = 14'h018;
    localparam logic [AW-1:0] A_CORE  = 14'h020;
    localparam logic [AW-1:0] A_CFG0  = 14'h021;
    localparam logic [AW-1:0] A_CFG1  = 14'h022;
    localparam logic [AW-1:0] A_CFG2  = 14'h023;
    localparam logic [AW-1:0] A_SAVE  = 14'h030;
    localparam logic [AW-1:0] A_WIN   = 14'h180;

    localparam int N_MODE = 4;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
#(
    parameter int N_SAVE = 16,
    parameter int N_WIN  = 4,
    parameter int IW     = 5
) (
    input  logic [AW-1:0] addr,
    output csr_cls_e      cls,
    output logic [IW-1:0] rw_idx,
    output logic [1:0]    ro_sel,
    output logic          mode_hit
);
    localparam int SAVE_LO = int'(A_SAVE);
    localparam int WIN_LO  = int'(A_WIN);

    int a_int;

    always_comb begin
        a_int    = int'(addr);
        cls      = CLS_UNDEF;
        rw_idx   = '0;
        ro_sel   = 2'd0;
        mode_hit = 1'b0;
        unique case (addr)
            A_MODE:  begin cls = CLS_RW; rw_idx = IW'(0); mode_hit = 1'b1; end
            A_UNITS: begin cls = CLS_RW; rw_idx = IW'(1); mode_hit = 1'b1; end
            A_XSTAT: begin cls = CLS_RW; rw_idx = IW'(2); mode_hit = 1'b1; end
            A_SPACE: begin cls = CLS_RW; rw_idx = IW'(3); mode_hit = 1'b1; end
            A_CORE:  begin cls = CLS_RO; ro_sel = 2'd0; end
            A_CFG0:  begin cls = CLS_RO; ro_sel = 2'd1; end
            A_CFG1:  begin cls = CLS_RO; ro_sel = 2'd2; end
            A_CFG2:  begin cls = CLS_RO; ro_sel = 2'd3; end
            default: begin
                if (a_int >= SAVE_LO && a_int < SAVE_LO + N_SAVE) begin
                    cls    = CLS_RW;
                    rw_idx = IW'(N_MODE + a_int - SAVE_LO);
                end else if (a_int >= WIN_LO && a_int < WIN_LO + N_WIN) begin
                    cls    = CLS_RW;
                    rw_idx = IW'(N_MODE + N_SAVE + a_int - WIN_LO);
                end
            end
        endcase
    end
endmodule

// File: rtl/csr_merge.sv
module csr_merge
    import csr_pkg::*;
#(
    parameter int DW = 64
) (
    input  csr_op_e       op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] new_val
);
    always_comb begin
        unique case (op)
            OP_XCHG: new_val = (src & mask) | (old_val & ~mask);
            default: new_val = src;
        endcase
    end
endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
    parameter int DW   = 64,
    parameter int N_RW = 24,
    parameter int IW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] q [N_RW];

    for (genvar i = 0; i < N_RW; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (we && idx == IW'(i)) begin
                q[i] <= wr_data;
            end
        end

        // R8: a register changes only when its own slot is written
        a_r8_slot_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && idx == IW'(i)) |=> $stable(q[i]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_RW; i++) begin
            if (idx == IW'(i)) rd_data = q[i];
        end
    end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_pkg::*;
#(
    parameter int            DW     = 64,
    parameter int            CORE_W = 8,
    parameter int            N_SAVE = 16,
    parameter int            N_WIN  = 4,
    parameter logic [DW-1:0] CFG0   = 64'h0000_0000_0003_0102,
    parameter logic [DW-1:0] CFG1   = 64'h0000_0000_0000_4420,
    parameter logic [DW-1:0] CFG2   = 64'h0000_0000_8000_0007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [13:0]       req_addr,
    input  logic [DW-1:0]     req_src,
    input  logic [DW-1:0]     req_mask,
    input  logic [1:0]        req_plv,
    input  logic [CORE_W-1:0] core_id,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic              exc_valid,
    output logic [5:0]        exc_cause,
    output logic              flush_req
);
    localparam int N_RW = N_MODE + N_SAVE + N_WIN;
    localparam int IW   = $clog2(N_RW);

    csr_op_e       op;
    csr_cls_e      cls;
    logic [IW-1:0] rw_idx;
    logic [1:0]    ro_sel;
    logic          mode_hit;
    logic [DW-1:0] bank_q;
    logic [DW-1:0] ro_val;
    logic [DW-1:0] old_val;
    logic [DW-1:0] new_val;
    logic          is_user;
    logic          is_wr;
    logic          we;

    rsp_state_e    st_q, st_d;
    logic [DW-1:0] data_d;
    logic [CW-1:0] cause_d;
    logic          flush_d;

    assign op      = csr_op_e'(req_op);
    assign is_user = (req_plv == PLV_USER);
    assign is_wr   = (op == OP_WRITE) || (op == OP_XCHG);

    csr_decode #(.N_SAVE(N_SAVE), .N_WIN(N_WIN), .IW(IW)) u_dec (
        .addr     (req_addr),
        .cls      (cls),
        .rw_idx   (rw_idx),
        .ro_sel   (ro_sel),
        .mode_hit (mode_hit)
    );

    csr_bank #(.DW(DW), .N_RW(N_RW), .IW(IW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .idx     (rw_idx),
        .wr_data (new_val),
        .rd_data (bank_q)
    );

    csr_merge #(.DW(DW)) u_merge (
        .op      (op),
        .old_val (old_val),
        .src     (req_src),
        .mask    (req_mask),
        .new_val (new_val)
    );

    always_comb begin
        unique case (ro_sel)
            2'd0:    ro_val = DW'(core_id);
            2'd1:    ro_val = CFG0;
            2'd2:    ro_val = CFG1;
            default: ro_val = CFG2;
        endcase
    end

    always_comb begin
        unique case (cls)
            CLS_RW:  old_val = bank_q;
            CLS_RO:  old_val = ro_val;
            default: old_val = '0;
        endcase
    end

    // next response state and the values that go with it
    always_comb begin
        st_d    = ST_IDLE;
        cause_d = '0;
        if (req_valid) begin
            if (is_user) begin
                st_d    = ST_TRAP;
                cause_d = CAUSE_PRIV;
            end else if (cls == CLS_RO && is_wr) begin
                st_d    = ST_TRAP;
                cause_d = CAUSE_RO;
            end else begin
                st_d    = ST_DONE;
            end
        end
    end

    assign we      = req_valid && !is_user && (cls == CLS_RW) && is_wr;
    assign data_d  = (st_d == ST_DONE) ? old_val : '0;
    assign flush_d = we && mode_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data  <= '0;
            exc_cause <= '0;
            flush_req <= 1'b0;
        end else begin
            rsp_data  <= data_d;
            exc_cause <= cause_d;
            flush_req <= flush_d;
        end
    end

    assign rsp_valid = (st_q != ST_IDLE);
    assign exc_valid = (st_q == ST_TRAP);

    // R10: one response per request, one cycle later
    a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R1: user level always traps with the privilege cause
    a_r1_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_plv == PLV_USER |=> exc_valid && exc_cause == CAUSE_PRIV && !flush_req);
    // R4: writes to read-only numbers trap
    a_r4_ro_write_traps: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_plv != PLV_USER && cls == CLS_RO && req_op != 2'd0 && req_op != 2'd3
        |=> exc_valid && exc_cause == CAUSE_RO && rsp_data == '0);
    // R2, R3: undefined numbers answer zero without trap
    a_r2_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_plv != PLV_USER && cls == CLS_UNDEF
        |=> rsp_data == '0 && !exc_valid && !flush_req);
    // R7: reads never flush, and a trap never flushes
    a_r7_read_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_op == 2'd0 || req_op == 2'd3) |=> !flush_req);
    a_r7_trap_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !flush_req);
    a_r7_idle_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !flush_req);
endmodule

// File: tb/sim_csr_access_unit.sv
module sim_csr_access_unit;
    localparam int          CLK_PERIOD = 10;
    localparam int          DW         = 64;
    localparam logic [63:0] C0 = 64'h0000_0000_0003_0102;
    localparam logic [63:0] C1 = 64'h0000_0000_0000_4420;
    localparam logic [63:0] C2 = 64'h0000_0000_8000_0007;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [13:0]   req_addr = '0;
    logic [DW-1:0] req_src = '0;
    logic [DW-1:0] req_mask = '0;
    logic [1:0]    req_plv = '0;
    logic [7:0]    core_id = 8'h5A;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          exc_valid;
    logic [5:0]    exc_cause;
    logic          flush_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [DW-1:0] r_data;
    logic          r_valid, r_exc, r_flush;
    logic [5:0]    r_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_access_unit #(.DW(DW), .CORE_W(8), .N_SAVE(16), .N_WIN(4),
                      .CFG0(C0), .CFG1(C1), .CFG2(C2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_src(req_src), .req_mask(req_mask),
        .req_plv(req_plv), .core_id(core_id), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .flush_req(flush_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample the response at the next falling edge
    task automatic do_op(input logic [1:0] op, input logic [13:0] a,
                         input logic [DW-1:0] s, input logic [DW-1:0] m, input logic [1:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_src = s; req_mask = m; req_plv = p;
        @(negedge clk);
        req_valid = 1'b0;
        r_valid = rsp_valid; r_data = rsp_data; r_exc = exc_valid;
        r_cause = exc_cause; r_flush = flush_req;
    endtask

    task automatic t_reset();
        chk("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R11 exc_valid after reset", 64'(exc_valid), 64'd0);
        chk("R11 flush_req after reset", 64'(flush_req), 64'd0);
        do_op(2'd0, 14'h000, '0, '0, 2'd0);
        chk("R11 mode reg reset value", r_data, 64'd0);
        do_op(2'd0, 14'h035, '0, '0, 2'd0);
        chk("R11 scratch reset value", r_data, 64'd0);
        do_op(2'd0, 14'h183, '0, '0, 2'd0);
        chk("R11 window reset value", r_data, 64'd0);
    endtask

    task automatic t_write_old();
        do_op(2'd1, 14'h030, 64'hAAAA_0000_1111_2222, '0, 2'd0);
        chk("R5 first write returns old 0", r_data, 64'd0);
        chk("R10 rsp_valid on write", 64'(r_valid), 64'd1);
        do_op(2'd1, 14'h030, 64'h0123_4567_89AB_CDEF, '0, 2'd0);
        chk("R5 second write returns old", r_data, 64'hAAAA_0000_1111_2222);
        do_op(2'd0, 14'h030, '0, '0, 2'd0);
        chk("R5 readback", r_data, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_banks();
        for (int i = 0; i < 16; i++)
            do_op(2'd1, 14'(14'h030 + i), 64'hC0DE_0000_0000_0000 | 64'(i * 17 + 3), '0, 2'd0);
        for (int i = 0; i < 4; i++)
            do_op(2'd1, 14'(14'h180 + i), 64'h0000_7700_0000_0000 | 64'(i + 100), '0, 2'd0);
        for (int i = 0; i < 16; i++) begin
            do_op(2'd0, 14'(14'h030 + i), '0, '0, 2'd0);
            chk("R8 scratch readback", r_data, 64'hC0DE_0000_0000_0000 | 64'(i * 17 + 3));
        end
        for (int i = 0; i < 4; i++) begin
            do_op(2'd0, 14'(14'h180 + i), '0, '0, 2'd0);
            chk("R8 window readback", r_data, 64'h0000_7700_0000_0000 | 64'(i + 100));
        end
    endtask

    task automatic t_xchg();
        do_op(2'd1, 14'h181, 64'hFFFF_0000_FFFF_0000, '0, 2'd0);
        do_op(2'd2, 14'h181, 64'h1234_5678_9ABC_DEF0, 64'h00FF_00FF_00FF_00FF, 2'd0);
        chk("R6 exchange returns old", r_data, 64'hFFFF_0000_FFFF_0000);
        chk("R6 exchange no trap", 64'(r_exc), 64'd0);
        do_op(2'd0, 14'h181, '0, '0, 2'd0);
        chk("R6 merged value", r_data, 64'hFF34_0078_FFBC_00F0);
        do_op(2'd2, 14'h181, 64'd0, 64'd0, 2'd0);
        do_op(2'd3, 14'h181, '0, '0, 2'd0);
        chk("R6 zero mask keeps value (spare op reads)", r_data, 64'hFF34_0078_FFBC_00F0);
    endtask

    task automatic t_flush();
        do_op(2'd1, 14'h000, 64'h8, '0, 2'd0);
        chk("R7 flush on mode write", 64'(r_flush), 64'd1);
        do_op(2'd2, 14'h018, 64'h3F, 64'hF, 2'd0);
        chk("R7 flush on space-id exchange", 64'(r_flush), 64'd1);
        do_op(2'd1, 14'h005, 64'h1, '0, 2'd0);
        chk("R7 flush on status write", 64'(r_flush), 64'd1);
        do_op(2'd1, 14'h001, 64'h2, '0, 2'd0);
        chk("R7 flush on unit-enable write", 64'(r_flush), 64'd1);
        do_op(2'd0, 14'h018, '0, '0, 2'd0);
        chk("R7 no flush on read", 64'(r_flush), 64'd0);
        chk("R6 masked space-id value", r_data, 64'hF);
        do_op(2'd1, 14'h032, 64'h9, '0, 2'd0);
        chk("R7 no flush on scratch write", 64'(r_flush), 64'd0);
    endtask

    task automatic t_readonly();
        do_op(2'd0, 14'h020, '0, '0, 2'd0);
        chk("R9 core id read", r_data, 64'h5A);
        chk("R9 read-only read no trap", 64'(r_exc), 64'd0);
        do_op(2'd0, 14'h022, '0, '0, 2'd0);
        chk("R9 cfg1 read", r_data, C1);
        do_op(2'd0, 14'h023, '0, '0, 2'd0);
        chk("R9 cfg2 read", r_data, C2);
        do_op(2'd1, 14'h021, 64'hDEAD, '0, 2'd0);
        chk("R4 write traps", 64'(r_exc), 64'd1);
        chk("R4 trap cause", 64'(r_cause), 64'h0D);
        chk("R4 trap data zero", r_data, 64'd0);
        chk("R4 trap no flush", 64'(r_flush), 64'd0);
        do_op(2'd0, 14'h021, '0, '0, 2'd0);
        chk("R4 cfg0 unchanged", r_data, C0);
        do_op(2'd2, 14'h020, 64'hFF, 64'hFF, 2'd1);
        chk("R4 exchange traps", 64'(r_cause), 64'h0D);
    endtask

    task automatic t_undef();
        do_op(2'd0, 14'h006, '0, '0, 2'd0);
        chk("R2 undefined read zero", r_data, 64'd0);
        chk("R2 undefined read no trap", 64'(r_exc), 64'd0);
        do_op(2'd1, 14'h3FFF, 64'h1234, '0, 2'd0);
        chk("R3 undefined write returns zero", r_data, 64'd0);
        chk("R3 undefined write no trap", 64'(r_exc), 64'd0);
        chk("R3 undefined write no flush", 64'(r_flush), 64'd0);
        do_op(2'd0, 14'h3FFF, '0, '0, 2'd0);
        chk("R3 undefined still zero", r_data, 64'd0);
        do_op(2'd2, 14'h040, 64'hFFFF, 64'hFFFF, 2'd0);
        do_op(2'd0, 14'h03F, '0, '0, 2'd0);
        chk("R3 neighbour scratch untouched", r_data, 64'hC0DE_0000_0000_0000 | 64'(15 * 17 + 3));
        do_op(2'd0, 14'h184, '0, '0, 2'd0);
        chk("R2 past window end reads zero", r_data, 64'd0);
    endtask

    task automatic t_user();
        do_op(2'd1, 14'h031, 64'h7777, '0, 2'd0);
        do_op(2'd1, 14'h031, 64'h9999, '0, 2'd3);
        chk("R1 user write traps", 64'(r_exc), 64'd1);
        chk("R1 user cause", 64'(r_cause), 64'h0E);
        chk("R1 user data zero", r_data, 64'd0);
        do_op(2'd0, 14'h020, '0, '0, 2'd3);
        chk("R1 user read traps", 64'(r_cause), 64'h0E);
        chk("R1 user read data zero", r_data, 64'd0);
        do_op(2'd1, 14'h000, 64'h1, '0, 2'd3);
        chk("R1 user mode write no flush", 64'(r_flush), 64'd0);
        do_op(2'd0, 14'h031, '0, '0, 2'd0);
        chk("R1 scratch unchanged by user write", r_data, 64'h7777);
        do_op(2'd0, 14'h000, '0, '0, 2'd0);
        chk("R1 mode unchanged by user write", r_data, 64'h8);
    endtask

    task automatic t_latency();
        do_op(2'd0, 14'h030, '0, '0, 2'd0);
        @(negedge clk);
        chk("R10 rsp_valid drops with no request", 64'(rsp_valid), 64'd0);
        chk("R10 exc_valid low with no request", 64'(exc_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_old();
        t_banks();
        t_xchg();
        t_flush();
        t_readonly();
        t_undef();
        t_user();
        t_latency();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule